// File: doc/BRIEF.md
# Low-Power-Domain Reset Control Bank

This block holds the software-visible reset controls of a low-power domain. A 32-bit register bus writes and reads a small set of word-addressed registers. Each stored bit drives a level reset output to a peripheral, a DMA channel group or a processor core. After power-on every controlled peripheral is held in reset until software releases it.

Besides the levels, the block watches each controllable field for changes. A write that moves a bit from 0 to 1 raises a one-cycle "reset asserted" event for that target. A write that moves it from 1 to 0 raises a one-cycle "reset released" event. Rewriting the value already stored produces no event.

For the two processor cores these events become a "turn off" pulse and a "turn on and restart" pulse. Those pulses are meant for a power sequencer that sits outside this block. A single DMA control bit fans out to the reset level and to the events of every DMA channel at once.

Top module: `lpd_reset_bank`

## Requirements
- R1: Out of reset the registers read: core control 0x17, DMA 0x1, debug 0x33, timer 0xF, full-power-domain 0x3. Peripheral target i reads bit i of PERIPH_RST_VAL; the default 0x3FFF gives 1 for targets 0 to 13 and 0 for targets 14 and 15.
- R2: On a cycle with bus_wr high, bus_wdata is written to the register at word address bus_addr. The map is: 0 core control, 1 DMA, 2 debug, 3 timer, 4 full-power-domain, 5+i peripheral target i (bit 0). bus_rdata shows the addressed register combinationally. Unmapped addresses read 0 and ignore writes.
- R3: Bits outside each register's writable mask read as zero and ignore writes. The masks are: core 0x17 (bit 3 reserved), DMA 0x1, debug 0x33, timer 0xF, full-power-domain 0x3, peripheral 0x1.
- R4: Events fire only when a written field value differs from the stored one. Rewriting the stored value produces no pulse and leaves every level unchanged.
- R5: Core control bits 0 and 1 drive core_rst[0] and core_rst[1] independently. A 0-to-1 change of bit n pulses core_off_p[n]. A 1-to-0 change pulses core_on_p[n].
- R6: The DMA bit drives all DMA_CH bits of dma_rst. Its 0-to-1 and 1-to-0 changes pulse every bit of dma_assert_p and of dma_release_p respectively.
- R7: Peripheral target i drives periph_rst[i]. A 0-to-1 change pulses periph_assert_p[i]; a 1-to-0 change pulses periph_release_p[i].
- R8: Levels and event pulses change on the clock edge that accepts the write. Each pulse lasts exactly one cycle.
- R9: core_misc_rst is {core bit 4, core bit 2}. dbg_rst, tmr_rst and fpd_rst follow their stored registers with the reserved bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| core_rst | output | 2 | Core reset levels |
| core_off_p | output | 2 | Per-core turn-off pulse |
| core_on_p | output | 2 | Per-core turn-on-and-restart pulse |
| core_misc_rst | output | 2 | Core register bits 4 and 2 |
| dma_rst | output | DMA_CH | DMA channel reset levels |
| dma_assert_p | output | DMA_CH | DMA channel reset-asserted pulses |
| dma_release_p | output | DMA_CH | DMA channel reset-released pulses |
| periph_rst | output | NUM_PERIPH | Peripheral reset levels |
| periph_assert_p | output | NUM_PERIPH | Peripheral reset-asserted pulses |
| periph_release_p | output | NUM_PERIPH | Peripheral reset-released pulses |
| dbg_rst | output | 8 | Debug reset register value |
| tmr_rst | output | 4 | Timer reset register value |
| fpd_rst | output | 2 | Full-power-domain reset register value |

## Verification
On every cycle the assertions check several links between a field's events and its stored level. A rise event must come with the level now set and previously clear, and a fall event with the reverse. A field with no write must hold its value. A rewrite of the stored core value must leave both core pulse vectors silent, and a write to an unmapped address must leave the levels untouched. Only the bench's scenarios can show the things that depend on chosen values: the reset contents, the reserved-bit masking seen through read-back, the DMA fan-out to every channel, and the exact mapping of core bits to the off and on pulses.

// File: rtl/rstbank_pkg.sv
package rstbank_pkg;

  localparam int unsigned DATA_W = 32;

  // core control register
  localparam int unsigned CORE_W    = 5;
  localparam logic [CORE_W-1:0] CORE_MASK = 5'h17;
  localparam logic [CORE_W-1:0] CORE_INIT = 5'h17;
  localparam int unsigned NUM_CORES = 2;

  // multi-bit level registers
  localparam int unsigned DBG_W = 8;
  localparam logic [DBG_W-1:0] DBG_MASK = 8'h33;
  localparam logic [DBG_W-1:0] DBG_INIT = 8'h33;
  localparam int unsigned TMR_W = 4;
  localparam logic [TMR_W-1:0] TMR_MASK = 4'hF;
  localparam logic [TMR_W-1:0] TMR_INIT = 4'hF;
  localparam int unsigned FPD_W = 2;
  localparam logic [FPD_W-1:0] FPD_MASK = 2'h3;
  localparam logic [FPD_W-1:0] FPD_INIT = 2'h3;

  // word addresses
  localparam int unsigned ADDR_CORE   = 0;
  localparam int unsigned ADDR_DMA    = 1;
  localparam int unsigned ADDR_DBG    = 2;
  localparam int unsigned ADDR_TMR    = 3;
  localparam int unsigned ADDR_FPD    = 4;
  localparam int unsigned PERIPH_BASE = 5;

  // bits that go 0 -> 1 between old and new
  function automatic logic [DATA_W-1:0] set_edges(input logic [DATA_W-1:0] old_v,
                                                  input logic [DATA_W-1:0] new_v);
    return new_v & ~old_v;
  endfunction

  // bits that go 1 -> 0 between old and new
  function automatic logic [DATA_W-1:0] clr_edges(input logic [DATA_W-1:0] old_v,
                                                  input logic [DATA_W-1:0] new_v);
    return old_v & ~new_v;
  endfunction

endpackage

// File: rtl/rst_field.sv
module rst_field #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '1,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] rise_p,
  output logic [W-1:0] fall_p
);
  import rstbank_pkg::*;

  logic [W-1:0]      nxt;
  logic [DATA_W-1:0] rise_w;
  logic [DATA_W-1:0] fall_w;
  logic              edge_unused;

  assign nxt    = wdata & MASK;
  assign rise_w = set_edges(DATA_W'(q), DATA_W'(nxt));
  assign fall_w = clr_edges(DATA_W'(q), DATA_W'(nxt));
  assign edge_unused = ^{rise_w, fall_w};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= RST_VAL & MASK;
      rise_p <= '0;
      fall_p <= '0;
    end else begin
      rise_p <= '0;
      fall_p <= '0;
      if (wr_en) begin
        q      <= nxt;
        rise_p <= rise_w[W-1:0];
        fall_p <= fall_w[W-1:0];
      end
    end
  end

  // R7 R8: a rise event comes with the bit now set and previously clear
  assert_rise_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_p != '0) |-> (((rise_p & q) == rise_p) && ((rise_p & $past(q)) == '0)));

  // R7 R8: a fall event comes with the bit now clear and previously set
  assert_fall_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_p != '0) |-> (((fall_p & q) == '0) && ((fall_p & $past(q)) == fall_p)));

  // R4: without a write the field holds and no event follows
  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(q) && rise_p == '0 && fall_p == '0));

endmodule

// File: rtl/rst_core_map.sv
module rst_core_map (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [rstbank_pkg::CORE_W-1:0]      q,
  input  logic [rstbank_pkg::CORE_W-1:0]      rise_p,
  input  logic [rstbank_pkg::CORE_W-1:0]      fall_p,
  output logic [rstbank_pkg::NUM_CORES-1:0]   core_rst,
  output logic [rstbank_pkg::NUM_CORES-1:0]   core_off_p,
  output logic [rstbank_pkg::NUM_CORES-1:0]   core_on_p,
  output logic [1:0]                          core_misc_rst
);
  import rstbank_pkg::*;

  logic misc_edge_unused;

  genvar c;
  generate
    for (c = 0; c < NUM_CORES; c++) begin : g_core
      assign core_rst[c]   = q[c];
      assign core_off_p[c] = rise_p[c];
      assign core_on_p[c]  = fall_p[c];
    end
  endgenerate

  assign core_misc_rst    = {q[4], q[2]};
  assign misc_edge_unused = ^{rise_p[CORE_W-1:NUM_CORES], fall_p[CORE_W-1:NUM_CORES],
                              q[3]};

  // R5: a turn-on pulse only when the core has left reset
  assert_on_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_on_p != '0) |-> ((core_on_p & core_rst) == '0));

endmodule

// File: rtl/rst_fanout.sv
module rst_fanout #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lvl,
  input  logic         rise_p,
  input  logic         fall_p,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] asrt_o,
  output logic [N-1:0] rel_o
);

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_ch
      assign lvl_o[k]  = lvl;
      assign asrt_o[k] = rise_p;
      assign rel_o[k]  = fall_p;
    end
  endgenerate

  // R6: channel assert events follow a 0-to-1 change of the shared bit
  assert_fanout_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (asrt_o != '0) |-> (lvl_o == '1 && $past(lvl) == 1'b0));

endmodule

// File: rtl/lpd_reset_bank.sv
module lpd_reset_bank #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DMA_CH = 8,
  parameter int unsigned NUM_PERIPH = 16,
  parameter logic [NUM_PERIPH-1:0] PERIPH_RST_VAL = 16'h3FFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [1:0]            core_rst,
  output logic [1:0]            core_off_p,
  output logic [1:0]            core_on_p,
  output logic [1:0]            core_misc_rst,
  output logic [DMA_CH-1:0]     dma_rst,
  output logic [DMA_CH-1:0]     dma_assert_p,
  output logic [DMA_CH-1:0]     dma_release_p,
  output logic [NUM_PERIPH-1:0] periph_rst,
  output logic [NUM_PERIPH-1:0] periph_assert_p,
  output logic [NUM_PERIPH-1:0] periph_release_p,
  output logic [7:0]            dbg_rst,
  output logic [3:0]            tmr_rst,
  output logic [1:0]            fpd_rst
);
  import rstbank_pkg::*;

  localparam int unsigned MAP_END = PERIPH_BASE + NUM_PERIPH;

  // address decode
  logic we_core, we_dma, we_dbg, we_tmr, we_fpd;
  logic addr_mapped;
  logic [NUM_PERIPH-1:0] we_periph;

  assign we_core = bus_wr && (bus_addr == ADDR_W'(ADDR_CORE));
  assign we_dma  = bus_wr && (bus_addr == ADDR_W'(ADDR_DMA));
  assign we_dbg  = bus_wr && (bus_addr == ADDR_W'(ADDR_DBG));
  assign we_tmr  = bus_wr && (bus_addr == ADDR_W'(ADDR_TMR));
  assign we_fpd  = bus_wr && (bus_addr == ADDR_W'(ADDR_FPD));
  assign addr_mapped = (32'(bus_addr) < MAP_END);

  // core control register
  logic [CORE_W-1:0] core_q, core_rise, core_fall;

  rst_field #(.W(CORE_W), .RST_VAL(CORE_INIT), .MASK(CORE_MASK)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_en(we_core), .wdata(bus_wdata[CORE_W-1:0]),
    .q(core_q), .rise_p(core_rise), .fall_p(core_fall)
  );

  rst_core_map u_core_map (
    .clk(clk), .rst_n(rst_n), .q(core_q), .rise_p(core_rise), .fall_p(core_fall),
    .core_rst(core_rst), .core_off_p(core_off_p), .core_on_p(core_on_p),
    .core_misc_rst(core_misc_rst)
  );

  // DMA group register
  logic dma_q, dma_rise, dma_fall;

  rst_field #(.W(1), .RST_VAL(1'b1), .MASK(1'b1)) u_dma (
    .clk(clk), .rst_n(rst_n), .wr_en(we_dma), .wdata(bus_wdata[0]),
    .q(dma_q), .rise_p(dma_rise), .fall_p(dma_fall)
  );

  rst_fanout #(.N(DMA_CH)) u_dma_fan (
    .clk(clk), .rst_n(rst_n), .lvl(dma_q), .rise_p(dma_rise), .fall_p(dma_fall),
    .lvl_o(dma_rst), .asrt_o(dma_assert_p), .rel_o(dma_release_p)
  );

  // level-only multi-bit registers
  logic [DBG_W-1:0] dbg_rise, dbg_fall;
  logic [TMR_W-1:0] tmr_rise, tmr_fall;
  logic [FPD_W-1:0] fpd_rise, fpd_fall;
  logic             level_edge_unused;

  rst_field #(.W(DBG_W), .RST_VAL(DBG_INIT), .MASK(DBG_MASK)) u_dbg (
    .clk(clk), .rst_n(rst_n), .wr_en(we_dbg), .wdata(bus_wdata[DBG_W-1:0]),
    .q(dbg_rst), .rise_p(dbg_rise), .fall_p(dbg_fall)
  );

  rst_field #(.W(TMR_W), .RST_VAL(TMR_INIT), .MASK(TMR_MASK)) u_tmr (
    .clk(clk), .rst_n(rst_n), .wr_en(we_tmr), .wdata(bus_wdata[TMR_W-1:0]),
    .q(tmr_rst), .rise_p(tmr_rise), .fall_p(tmr_fall)
  );

  rst_field #(.W(FPD_W), .RST_VAL(FPD_INIT), .MASK(FPD_MASK)) u_fpd (
    .clk(clk), .rst_n(rst_n), .wr_en(we_fpd), .wdata(bus_wdata[FPD_W-1:0]),
    .q(fpd_rst), .rise_p(fpd_rise), .fall_p(fpd_fall)
  );

  assign level_edge_unused = ^{dbg_rise, dbg_fall, tmr_rise, tmr_fall, fpd_rise, fpd_fall,
                               bus_wdata[31:DBG_W]};

  // single-bit peripheral targets
  genvar p;
  generate
    for (p = 0; p < NUM_PERIPH; p++) begin : g_periph
      assign we_periph[p] = bus_wr && (bus_addr == ADDR_W'(PERIPH_BASE + p));
      rst_field #(.W(1), .RST_VAL(PERIPH_RST_VAL[p]), .MASK(1'b1)) u_tgt (
        .clk(clk), .rst_n(rst_n), .wr_en(we_periph[p]), .wdata(bus_wdata[0]),
        .q(periph_rst[p]), .rise_p(periph_assert_p[p]), .fall_p(periph_release_p[p])
      );
    end
  endgenerate

  // read multiplexer
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADDR_CORE)) bus_rdata = 32'(core_q);
    if (bus_addr == ADDR_W'(ADDR_DMA))  bus_rdata = 32'(dma_q);
    if (bus_addr == ADDR_W'(ADDR_DBG))  bus_rdata = 32'(dbg_rst);
    if (bus_addr == ADDR_W'(ADDR_TMR))  bus_rdata = 32'(tmr_rst);
    if (bus_addr == ADDR_W'(ADDR_FPD))  bus_rdata = 32'(fpd_rst);
    for (int i = 0; i < NUM_PERIPH; i++) begin
      if (bus_addr == ADDR_W'(PERIPH_BASE + i)) bus_rdata = 32'(periph_rst[i]);
    end
  end

  // R4: rewriting the stored core value raises no core pulse
  assert_core_rewrite_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_core && ((bus_wdata[CORE_W-1:0] & CORE_MASK) == core_q))
      |=> (core_off_p == '0 && core_on_p == '0));

  // R2: a write to an unmapped address leaves every level alone
  assert_unmapped_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !addr_mapped) |=> ($stable(periph_rst) && $stable(core_rst) &&
                                  $stable(dma_rst) && periph_assert_p == '0 &&
                                  periph_release_p == '0));

  // R5: a turn-off pulse only when the core has entered reset
  assert_off_after_assert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_off_p != '0) |-> ((core_off_p & ~core_rst) == '0));

endmodule

// File: tb/sim_lpd_reset_bank.sv
module sim_lpd_reset_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NV = 10;

  // {addr[4:0], wdata[31:0], expected read[31:0]}
  localparam logic [68:0] VEC [0:NV-1] = '{
    {5'd0,  32'hFFFF_FFFF, 32'h0000_0017},
    {5'd0,  32'h0000_0008, 32'h0000_0000},
    {5'd2,  32'h0000_00FF, 32'h0000_0033},
    {5'd2,  32'h0000_0012, 32'h0000_0012},
    {5'd3,  32'h0000_005A, 32'h0000_000A},
    {5'd4,  32'h0000_0000, 32'h0000_0000},
    {5'd1,  32'hFFFF_FFFE, 32'h0000_0000},
    {5'd5,  32'h0000_0003, 32'h0000_0001},
    {5'd20, 32'h0000_000F, 32'h0000_0001},
    {5'd25, 32'h0000_0001, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0] core_rst, core_off_p, core_on_p, core_misc_rst;
  logic [7:0] dma_rst, dma_assert_p, dma_release_p;
  logic [NP-1:0] periph_rst, periph_assert_p, periph_release_p;
  logic [7:0] dbg_rst;
  logic [3:0] tmr_rst;
  logic [1:0] fpd_rst;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpd_reset_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_rst(core_rst), .core_off_p(core_off_p), .core_on_p(core_on_p),
    .core_misc_rst(core_misc_rst),
    .dma_rst(dma_rst), .dma_assert_p(dma_assert_p), .dma_release_p(dma_release_p),
    .periph_rst(periph_rst), .periph_assert_p(periph_assert_p),
    .periph_release_p(periph_release_p),
    .dbg_rst(dbg_rst), .tmr_rst(tmr_rst), .fpd_rst(fpd_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // write accepted at the next rising edge; returns 1 time unit after it
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // expected reset content of each word address
  function automatic logic [31:0] init_val(input int a);
    case (a)
      0: return 32'h17;
      1: return 32'h1;
      2: return 32'h33;
      3: return 32'hF;
      4: return 32'h3;
      default: return (a >= 5 && a < 5 + NP) ? 32'((16'h3FFF >> (a - 5)) & 16'h1) : 32'h0;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    do_reset();

    // R1: reset contents and levels
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), got);
      check($sformatf("R1 reset read addr %0d", a), got, init_val(a));
    end
    check("R1 core_rst", 32'(core_rst), 32'h3);
    check("R1 dma_rst", 32'(dma_rst), 32'hFF);
    check("R1 periph_rst", 32'(periph_rst), 32'h3FFF);
    check("R9 reset core_misc_rst", 32'(core_misc_rst), 32'h3);
    check("R9 reset dbg/tmr/fpd", {18'h0, dbg_rst, tmr_rst, fpd_rst}, {18'h0, 8'h33, 4'hF, 2'h3});

    // R2 R3: vector walk of write then read-back
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][68:64], VEC[k][63:32]);
      rd(VEC[k][68:64], got);
      check($sformatf("R2 R3 vector %0d", k), got, VEC[k][31:0]);
    end
    check("R9 dbg/tmr/fpd levels", {18'h0, dbg_rst, tmr_rst, fpd_rst}, {18'h0, 8'h12, 4'hA, 2'h0});

    // directed tests from a fresh reset
    do_reset();

    // R5 R8: release core 0 only
    wr(5'd0, 32'h16);
    check("R5 core_on_p core0", 32'(core_on_p), 32'h1);
    check("R5 core_off_p quiet", 32'(core_off_p), 32'h0);
    check("R8 core_rst same edge", 32'(core_rst), 32'h2);
    step();
    check("R8 core_on_p one cycle", 32'(core_on_p), 32'h0);

    // R4: rewrite same value
    wr(5'd0, 32'h16);
    check("R4 core rewrite no on", 32'(core_on_p), 32'h0);
    check("R4 core rewrite no off", 32'(core_off_p), 32'h0);
    check("R4 core level kept", 32'(core_rst), 32'h2);

    // R5: core0 into reset, core1 out, same write
    wr(5'd0, 32'h15);
    check("R5 core_off_p core0", 32'(core_off_p), 32'h1);
    check("R5 core_on_p core1", 32'(core_on_p), 32'h2);
    check("R5 core_rst", 32'(core_rst), 32'h1);

    // R9: misc bits
    wr(5'd0, 32'h03);
    check("R9 core_misc_rst cleared", 32'(core_misc_rst), 32'h0);
    check("R9 core pulses none for misc", {30'h0, core_off_p | core_on_p}, 32'h2);

    // R6: DMA fan-out
    wr(5'd1, 32'h0);
    check("R6 dma_rst released", 32'(dma_rst), 32'h0);
    check("R6 dma_release_p all", 32'(dma_release_p), 32'hFF);
    check("R6 dma_assert_p none", 32'(dma_assert_p), 32'h0);
    step();
    check("R8 dma_release_p one cycle", 32'(dma_release_p), 32'h0);
    wr(5'd1, 32'h0);
    check("R4 dma rewrite quiet", 32'(dma_release_p | dma_assert_p), 32'h0);
    wr(5'd1, 32'h1);
    check("R6 dma_assert_p all", 32'(dma_assert_p), 32'hFF);
    check("R6 dma_rst held", 32'(dma_rst), 32'hFF);

    // R7: peripheral target 2 (address 7)
    wr(5'd7, 32'h0);
    check("R7 periph release pulse", 32'(periph_release_p), 32'h0004);
    check("R7 periph level", 32'(periph_rst), 32'h3FFB);
    wr(5'd7, 32'h2);
    check("R3 R4 periph reserved bit no event", 32'(periph_release_p | periph_assert_p), 32'h0);
    check("R3 periph level kept", 32'(periph_rst), 32'h3FFB);
    wr(5'd7, 32'h1);
    check("R7 periph assert pulse", 32'(periph_assert_p), 32'h0004);
    step();
    check("R8 periph pulse one cycle", 32'(periph_assert_p), 32'h0);

    // R7: target 14 starts released (address 19)
    wr(5'd19, 32'h1);
    check("R7 periph 14 assert", 32'(periph_assert_p), 32'h4000);
    check("R7 periph 14 level", 32'(periph_rst), 32'h7FFF);

    // R2: unmapped write has no effect
    wr(5'd31, 32'hFFFF_FFFF);
    check("R2 unmapped periph level", 32'(periph_rst), 32'h7FFF);
    check("R2 unmapped core level", 32'(core_rst), 32'h3);
    check("R2 unmapped no events", 32'(periph_assert_p | periph_release_p), 32'h0);
    rd(5'd31, got);
    check("R2 unmapped reads zero", got, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule